// File: doc/BRIEF.md
# Serial-Clock Hold Detector for Converter Resynchronization and Power-Down

This block sits beside the serial output logic of a delta-sigma converter. It watches the serial data clock, which normally rests low. When a host holds that line high, the block measures how long it stays high. It measures in whole conversion frames, by counting the frame-start strobe that the output block raises once per conversion. After four such frames it holds the modulator in reset. It also takes over the shared data/ready pin: first a one-cycle low pulse, then a steady high.

If the line falls before twenty frames have passed, the falling edge releases the modulator and frame timing restarts from that point. This is how several converters are aligned to a common edge; a host that must absorb up to one frame of skew between devices holds the line for at least five frames. If the line stays high for twenty frames, the block also raises a power-down request, which is cleared by the next falling edge. After either kind of release, the block marks the first frame strobe as the first frame whose data is valid. The analog modulator and the power gating lie outside this block and see only the request outputs.

The serial clock is asynchronous to the system clock and passes through a synchronizer first. The state machine has five states. ST_RUN is normal operation. ST_FLAG is the one-cycle low pulse on the pin. ST_HOLD is the modulator held in reset. ST_PDOWN is power-down. ST_SETTLE waits for the first frame after release.

The transitions are:
- ST_RUN→ST_FLAG when the high count reaches the sync threshold.
- ST_FLAG→ST_HOLD unconditionally.
- ST_HOLD→ST_SETTLE when the synchronized line is low.
- ST_HOLD→ST_PDOWN when the count reaches the power-down threshold.
- ST_PDOWN→ST_SETTLE when the synchronized line is low.
- ST_SETTLE→ST_RUN on the first frame strobe.

Top module: `sclk_hold_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving it, all outputs are inactive (mod_rst_req=0, pwr_down_req=0, pin_force_en=0, pin_force_val=0, first_valid=0), whatever the serial clock does.
- R2: A high interval of the serial clock that covers fewer than SYNC_FRAMES (default 4) frame strobes causes no output change. The count is not cumulative: a low level clears it.
- R3: On reaching SYNC_FRAMES strobes with the line high, the pin is forced low (pin_force_en=1, pin_force_val=0) for exactly one system clock. After that it is forced high (pin_force_en=1, pin_force_val=1).
- R4: From the end of that low pulse until release, mod_rst_req=1 and the pin is forced high.
- R5: If the line falls after SYNC_FRAMES but before PD_FRAMES (default 20) strobes, mod_rst_req and the pin override are released and no power-down request is ever raised.
- R6: On reaching PD_FRAMES strobes with the line high, pwr_down_req=1 together with mod_rst_req=1 and the pin forced high. All three stay asserted for as long as the line remains high, however many further frames pass.
- R7: A falling serial clock during power-down clears pwr_down_req, mod_rst_req and pin_force_en together.
- R8: After a release, first_valid pulses for exactly one system clock, in the same cycle as the first frame strobe, and not again in the frames that follow.
- R9: Frame strobes seen while the line is low do not advance the high count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial data clock, asynchronous, rests low |
| frame_strobe | input | 1 | One-cycle pulse at the start of each conversion frame |
| mod_rst_req | output | 1 | Hold the modulator in reset |
| pwr_down_req | output | 1 | Request power-down |
| pin_force_en | output | 1 | 1: the shared data/ready pin is driven to pin_force_val and the normal ready pattern is suppressed |
| pin_force_val | output | 1 | Level forced onto the pin while pin_force_en=1 |
| first_valid | output | 1 | Marks the first valid frame after a release |

## Verification
On every cycle, the checker confirms the relations between the outputs. The low pulse lasts one cycle and is followed by a forced high. A power-down request is never raised without a modulator reset. A modulator reset never occurs without the pin override. The valid-frame marker appears only together with a strobe and outside reset.

The frame counts themselves can be shown only by the bench's scenarios. These include the exact threshold behaviour at 3 versus 4 frames and at 19 versus 20 frames, the clearing of the count by a short low interval, saturation during a long power-down, and the single marker pulse after release.

// File: rtl/sclk_hold_pkg.sv
package sclk_hold_pkg;

    // Control states of the hold detector.
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,  // normal operation, pin owned by the output block
        ST_FLAG   = 3'd1,  // one-cycle low pulse on the pin
        ST_HOLD   = 3'd2,  // modulator held in reset, pin forced high
        ST_PDOWN  = 3'd3,  // power-down, pin forced high
        ST_SETTLE = 3'd4   // released, waiting for the first frame strobe
    } hold_state_e;

    // Bundle of control outputs produced from the state.
    typedef struct packed {
        logic mod_rst;
        logic pdown;
        logic force_en;
        logic force_val;
    } hold_ctl_t;

endpackage

// File: rtl/sclk_hold_sync.sv
module sclk_hold_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sclk_hold_frame_cnt.sv
module sclk_hold_frame_cnt #(
    parameter int SYNC_FRAMES = 4,
    parameter int PD_FRAMES   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_high,
    input  logic frame_strobe,
    output logic at_sync,
    output logic at_pd
);

    localparam int CNT_W = $clog2(PD_FRAMES + 1);
    localparam logic [CNT_W-1:0] SYNC_LIM = CNT_W'(SYNC_FRAMES);
    localparam logic [CNT_W-1:0] PD_LIM   = CNT_W'(PD_FRAMES);

    logic [CNT_W-1:0] hi_cnt;

    // Counts strobes while the line is high; a low level clears it at once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
        end else if (!line_high) begin
            hi_cnt <= '0;
        end else if (frame_strobe && (hi_cnt < PD_LIM)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign at_sync = line_high && (hi_cnt >= SYNC_LIM);
    assign at_pd   = line_high && (hi_cnt >= PD_LIM);

endmodule

// File: rtl/sclk_hold_ctrl.sv
module sclk_hold_ctrl
    import sclk_hold_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SYNC_FRAMES = 4,
    parameter int PD_FRAMES   = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic frame_strobe,
    output logic mod_rst_req,
    output logic pwr_down_req,
    output logic pin_force_en,
    output logic pin_force_val,
    output logic first_valid
);

    logic        sclk_s;
    logic        at_sync;
    logic        at_pd;
    hold_state_e state_q;
    hold_state_e state_d;
    hold_ctl_t   ctl;

    sclk_hold_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sclk),
        .q     (sclk_s)
    );

    sclk_hold_frame_cnt #(
        .SYNC_FRAMES (SYNC_FRAMES),
        .PD_FRAMES   (PD_FRAMES)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_high    (sclk_s),
        .frame_strobe (frame_strobe),
        .at_sync      (at_sync),
        .at_pd        (at_pd)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (at_sync)     state_d = ST_FLAG;
            ST_FLAG:                    state_d = ST_HOLD;
            ST_HOLD:   if (!sclk_s)     state_d = ST_SETTLE;
                       else if (at_pd)  state_d = ST_PDOWN;
            ST_PDOWN:  if (!sclk_s)     state_d = ST_SETTLE;
            ST_SETTLE: if (frame_strobe) state_d = ST_RUN;
            default:                    state_d = ST_RUN;
        endcase
    end

    // Output decoding.
    always_comb begin
        ctl         = '0;
        first_valid = 1'b0;
        unique case (state_q)
            ST_RUN:    ctl = '0;
            ST_FLAG:   ctl = '{mod_rst: 1'b1, pdown: 1'b0, force_en: 1'b1, force_val: 1'b0};
            ST_HOLD:   ctl = '{mod_rst: 1'b1, pdown: 1'b0, force_en: 1'b1, force_val: 1'b1};
            ST_PDOWN:  ctl = '{mod_rst: 1'b1, pdown: 1'b1, force_en: 1'b1, force_val: 1'b1};
            ST_SETTLE: first_valid = frame_strobe;
            default:   ctl = '0;
        endcase
    end

    assign mod_rst_req   = ctl.mod_rst;
    assign pwr_down_req  = ctl.pdown;
    assign pin_force_en  = ctl.force_en;
    assign pin_force_val = ctl.force_val;

endmodule

// File: rtl/sclk_hold_chk.sv
module sclk_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic frame_strobe,
    input logic mod_rst_req,
    input logic pwr_down_req,
    input logic pin_force_en,
    input logic pin_force_val,
    input logic first_valid
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!mod_rst_req && !pwr_down_req && !pin_force_en && !first_valid) else $error("reset outputs"); // R1
        end
    end

    AST_LOW_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_force_en && !pin_force_val) |=> (pin_force_en && pin_force_val)); // R3

    AST_RST_FORCES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        mod_rst_req |-> pin_force_en); // R4

    AST_PD_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_req |-> (mod_rst_req && pin_force_val)); // R6

    AST_PD_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down_req) |-> $past(mod_rst_req)); // R6

    AST_PD_EXIT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_down_req) |-> (!mod_rst_req && !pin_force_en)); // R7

    AST_FV_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (frame_strobe && !mod_rst_req && !pin_force_en)); // R8

endmodule

bind sclk_hold_ctrl sclk_hold_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_strobe  (frame_strobe),
    .mod_rst_req   (mod_rst_req),
    .pwr_down_req  (pwr_down_req),
    .pin_force_en  (pin_force_en),
    .pin_force_val (pin_force_val),
    .first_valid   (first_valid)
);

// File: tb/tb_sclk_hold_ctrl.sv
`timescale 1ns/1ps
module tb_sclk_hold_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic frame_strobe = 1'b0;
    logic mod_rst_req, pwr_down_req, pin_force_en, pin_force_val, first_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int low_pulses = 0;
    int fv_count = 0;
    int fv_stray = 0;

    always #2.5 clk = ~clk;

    sclk_hold_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sclk          (sclk),
        .frame_strobe  (frame_strobe),
        .mod_rst_req   (mod_rst_req),
        .pwr_down_req  (pwr_down_req),
        .pin_force_en  (pin_force_en),
        .pin_force_val (pin_force_val),
        .first_valid   (first_valid)
    );

    // Output monitors sampled away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (pin_force_en && !pin_force_val) low_pulses <= low_pulses + 1;
        if (first_valid) fv_count <= fv_count + 1;
        if (first_valid && !frame_strobe) fv_stray <= fv_stray + 1;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    // Entry: {sclk, frames[5:0], expected {mod_rst, pdown, force_en, force_val}}
    localparam int NV = 16;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 6'd2,  4'b0000},   // idle, strobes while low (R9)
        {1'b1, 6'd3,  4'b0000},   // 3 frames high: below threshold (R2)
        {1'b0, 6'd0,  4'b0000},   // low clears count (R2)
        {1'b1, 6'd3,  4'b0000},   // again 3, not cumulative (R2)
        {1'b1, 6'd1,  4'b1011},   // 4th frame: hold (R3 R4)
        {1'b1, 6'd15, 4'b1011},   // 19 frames: still hold (R4)
        {1'b1, 6'd1,  4'b1111},   // 20th frame: power-down (R6)
        {1'b1, 6'd6,  4'b1111},   // saturation, stays down (R6)
        {1'b0, 6'd0,  4'b0000},   // falling edge exits power-down (R7)
        {1'b0, 6'd5,  4'b0000},   // low strobes ignored (R9)
        {1'b1, 6'd3,  4'b0000},   // count starts fresh (R9)
        {1'b1, 6'd2,  4'b1011},   // total 5: hold (R4)
        {1'b0, 6'd0,  4'b0000},   // sync release (R5)
        {1'b0, 6'd25, 4'b0000},   // no late power-down (R5)
        {1'b1, 6'd4,  4'b1011},   // hold at exactly 4 (R3)
        {1'b0, 6'd0,  4'b0000}    // release (R5)
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frames(input int n);
        for (int f = 0; f < n; f++) begin
            frame_strobe = 1'b1;
            tick(1);
            frame_strobe = 1'b0;
            tick(7);
        end
    endtask

    task automatic apply(input logic lvl, input int n);
        sclk = lvl;
        tick(4);
        frames(n);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, mod_rst_req, pwr_down_req, pin_force_en, pin_force_val};
    endfunction

    initial begin
        // R1: reset state with line high and strobes running
        sclk = 1'b1;
        tick(2);
        frames(6);
        chk("R1 during reset", outs() | int'(first_valid) << 4, 0);
        sclk = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk("R1 after reset", outs() | int'(first_valid) << 4, 0);

        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][10], int'(VEC[v][9:4]));
            chk($sformatf("R2 R4 R5 R6 R7 R9 vector %0d", v), outs(), int'(VEC[v][3:0]));
        end

        // R3: exactly one low-pulse cycle on entry
        low_pulses = 0;
        apply(1'b1, 4);
        chk("R3 low pulse cycles", low_pulses, 1);
        chk("R3 pin held high", outs(), 4'b1011);

        // R8: one marker, on the first strobe after release
        apply(1'b0, 0);
        fv_count = 0;
        fv_stray = 0;
        frames(3);
        chk("R8 marker count", fv_count, 1);
        chk("R8 marker off strobe", fv_stray, 0);

        // R8 after power-down release, R7 exit
        apply(1'b1, 20);
        chk("R6 power-down", outs(), 4'b1111);
        apply(1'b0, 0);
        chk("R7 exit", outs(), 0);
        fv_count = 0;
        frames(4);
        chk("R8 marker after power-down", fv_count, 1);

        // R1: reset from power-down
        apply(1'b1, 20);
        rst_n = 1'b0;
        tick(1);
        chk("R1 reset from power-down", outs(), 0);
        sclk = 1'b0;
        rst_n = 1'b1;
        tick(4);
        chk("R1 idle after reset", outs(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule